// File: doc/BRIEF.md
# Flash Access Permission Checker

This block decides, for every access presented to a flash array, whether the access may go ahead. Each request names the partition (data or information), a byte address, and an operation kind: read, program, page erase, bank erase or instruction fetch. Software-visible configuration is held inside the block. It consists of a set of data-partition protection regions, a fallback permission set, one permission set per information page, one bank-erase enable bit per bank, and an execute key word. A mode input puts the block into a wipe-and-retire condition in which the software configuration is bypassed.

The decision is returned one clock after the request as a registered allow/error pair. A downstream sequencer launches the flash operation only on allow. On error it returns an error response to the requester.

Top module: `flash_guard`

## Requirements
- R1: After synchronous reset, every region is disabled, and the fallback permissions, information-page permissions, bank-erase enables and execute key are all zero, so every request is denied.
- R2: A data-partition region (config word: bit 0 enable, bit 1 read, bit 2 program, bit 3 page erase, bits 12:4 start page, bits 22:13 page count) matches page p only when it is enabled and start <= p < start + count. A count of zero never matches.
- R3: When several enabled regions match the same page, the permissions of the region with the lowest index apply.
- R4: A data-partition read, program or page erase that matches no enabled region uses the fallback permission word (bit 1 read, bit 2 program, bit 3 page erase).
- R5: Information-partition read, program and page erase use the permission word of that bank's page (same bit positions as R4), never the regions. Page indexes at or beyond the number of information pages per bank are denied.
- R6: Bank erase ignores regions, page permissions and partition. It is allowed only when the enable bit of the addressed bank is set.
- R7: An instruction fetch is allowed only when the execute key word equals 0xA26A38F7, the target is the data partition, and the page's effective read permission is set.
- R8: While the RMA mode input is high, read, program, page erase and bank erase are allowed everywhere regardless of configuration, and instruction fetch is denied.
- R9: The response is registered. chk_valid follows req_valid by one cycle. For a valid response exactly one of chk_allow and chk_err is high, and both are low when there is no response. Operation codes 5 to 7 are denied.
- R10: Configuration writes go to word address 0..N-1 for region N, then the fallback word, the bank-erase enable word (bit b for bank b), the execute key, and one word per information page (bank-major order). Unmapped addresses are ignored. A request in the same cycle as a write is judged on the configuration held before that write.
- R11: The page number is the byte address divided by the page size (2 KB by default). With 256 pages per bank, the bank is page / 256 (bank 1 starts at 0x80000), and the page within the bank is page mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_REGIONS+3+BANKS*INFO_PAGES) | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| rma_mode | input | 1 | Wipe mode, replaces software protection with fixed permissions |
| req_valid | input | 1 | Access request present |
| req_info | input | 1 | 1 = information partition, 0 = data partition |
| req_op | input | 3 | 0 read, 1 program, 2 page erase, 3 bank erase, 4 fetch |
| req_addr | input | ADDR_W | Byte address of the access |
| chk_valid | output | 1 | Decision present (one cycle after request) |
| chk_allow | output | 1 | Access permitted |
| chk_err | output | 1 | Access refused |

## Verification
The hardest situation to reach is one where overlapping enabled regions, a region of zero length, the fallback word and a same-cycle configuration write all bear on one decision. A random write stream seldom produces all of these at once. The bench builds them on purpose. It programs nested regions whose boundaries land one page either side of the probes, disables the winner to expose the loser, and issues a request in the very cycle that rewrites the region covering it. A long constrained-random phase then mixes region words with short page counts clustered in a narrow page window, so that overlaps occur often. Every cycle is compared against a behavioural model.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_PERASE = 3'd2,
    OP_BERASE = 3'd3,
    OP_FETCH  = 3'd4
  } fg_op_e;

  typedef struct packed {
    logic er;
    logic pg;
    logic rd;
  } fg_perm_t;

  localparam logic [31:0] FG_EXEC_KEY = 32'hA26A38F7;

  // config word field positions
  localparam int FLD_EN    = 0;
  localparam int FLD_RD    = 1;
  localparam int FLD_PG    = 2;
  localparam int FLD_ER    = 3;
  localparam int FLD_START = 4;

  function automatic fg_perm_t fg_perm_of(input logic [31:0] w);
    fg_perm_t p;
    p.rd = w[FLD_RD];
    p.pg = w[FLD_PG];
    p.er = w[FLD_ER];
    return p;
  endfunction

  function automatic logic fg_perm_op(input fg_perm_t p, input logic [2:0] op);
    case (op)
      OP_READ:   return p.rd;
      OP_PROG:   return p.pg;
      OP_PERASE: return p.er;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fg_cfg_regs.sv
module fg_cfg_regs
  import fg_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int PAGE_W      = 9,
  parameter int BANKS       = 2,
  parameter int INFO_TOTAL  = 8,
  parameter int CFG_AW      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [CFG_AW-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic                rg_en    [NUM_REGIONS],
  output logic [PAGE_W-1:0]   rg_start [NUM_REGIONS],
  output logic [PAGE_W:0]     rg_count [NUM_REGIONS],
  output fg_perm_t            rg_perm  [NUM_REGIONS],
  output fg_perm_t            dflt_perm,
  output logic [BANKS-1:0]    bank_en,
  output logic [31:0]         exec_key,
  output fg_perm_t            info_perm [INFO_TOTAL]
);

  localparam int A_DFLT = NUM_REGIONS;
  localparam int A_BANK = NUM_REGIONS + 1;
  localparam int A_KEY  = NUM_REGIONS + 2;
  localparam int A_INFO = NUM_REGIONS + 3;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    always_ff @(posedge clk) begin
      if (rst) begin
        rg_en[i]    <= 1'b0;
        rg_start[i] <= '0;
        rg_count[i] <= '0;
        rg_perm[i]  <= '0;
      end else if (we && addr == CFG_AW'(i)) begin
        rg_en[i]    <= wdata[FLD_EN];
        rg_start[i] <= wdata[FLD_START +: PAGE_W];
        rg_count[i] <= wdata[FLD_START + PAGE_W +: PAGE_W + 1];
        rg_perm[i]  <= fg_perm_of(wdata);
      end
    end
  end

  for (genvar j = 0; j < INFO_TOTAL; j++) begin : g_info
    always_ff @(posedge clk) begin
      if (rst) begin
        info_perm[j] <= '0;
      end else if (we && addr == CFG_AW'(A_INFO + j)) begin
        info_perm[j] <= fg_perm_of(wdata);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dflt_perm <= '0;
      bank_en   <= '0;
      exec_key  <= '0;
    end else if (we) begin
      if (addr == CFG_AW'(A_DFLT)) dflt_perm <= fg_perm_of(wdata);
      if (addr == CFG_AW'(A_BANK)) bank_en   <= wdata[BANKS-1:0];
      if (addr == CFG_AW'(A_KEY))  exec_key  <= wdata;
    end
  end

endmodule

// File: rtl/fg_region_match.sv
module fg_region_match
  import fg_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int PAGE_W      = 9
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              rg_en    [NUM_REGIONS],
  input  logic [PAGE_W-1:0] rg_start [NUM_REGIONS],
  input  logic [PAGE_W:0]   rg_count [NUM_REGIONS],
  input  fg_perm_t          rg_perm  [NUM_REGIONS],
  input  fg_perm_t          dflt_perm,
  output fg_perm_t          eff_perm
);

  localparam int CW = PAGE_W + 2;

  logic [NUM_REGIONS-1:0] hit;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
    logic [CW-1:0] lo, hi, pg;
    assign lo = {2'b00, rg_start[i]};
    assign hi = lo + {1'b0, rg_count[i]};
    assign pg = {2'b00, page};
    assign hit[i] = rg_en[i] && (pg >= lo) && (pg < hi);
  end

  // lowest index wins: scan from the highest so lower ones overwrite
  always_comb begin
    eff_perm = dflt_perm;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) eff_perm = rg_perm[i];
    end
  end

endmodule

// File: rtl/fg_decide.sv
module fg_decide
  import fg_pkg::*;
(
  input  logic       rma,
  input  logic [2:0] op,
  input  logic       info,
  input  logic       bank_ok,
  input  logic       key_ok,
  input  logic       info_in_range,
  input  fg_perm_t   info_p,
  input  fg_perm_t   data_p,
  output logic       allow
);

  always_comb begin
    allow = 1'b0;
    case (op)
      OP_READ, OP_PROG, OP_PERASE: begin
        if (rma)       allow = 1'b1;
        else if (info) allow = info_in_range && fg_perm_op(info_p, op);
        else           allow = fg_perm_op(data_p, op);
      end
      OP_BERASE: allow = rma || bank_ok;
      OP_FETCH:  allow = !rma && !info && key_ok && data_p.rd;
      default:   allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int PAGE_BYTES_LOG2 = 11,
  parameter int BANKS           = 2,
  parameter int NUM_REGIONS     = 4,
  parameter int INFO_PAGES      = 4
) (
  input  logic                                                clk,
  input  logic                                                rst,
  input  logic                                                cfg_we,
  input  logic [$clog2(NUM_REGIONS+3+BANKS*INFO_PAGES)-1:0]   cfg_addr,
  input  logic [31:0]                                         cfg_wdata,
  input  logic                                                rma_mode,
  input  logic                                                req_valid,
  input  logic                                                req_info,
  input  logic [2:0]                                          req_op,
  input  logic [ADDR_W-1:0]                                   req_addr,
  output logic                                                chk_valid,
  output logic                                                chk_allow,
  output logic                                                chk_err
);

  localparam int PAGE_W     = ADDR_W - PAGE_BYTES_LOG2;
  localparam int BANK_W     = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int PIB_W      = PAGE_W - BANK_W;
  localparam int INFO_TOTAL = BANKS * INFO_PAGES;
  localparam int IDX_W      = (INFO_TOTAL > 1) ? $clog2(INFO_TOTAL) : 1;
  localparam int CFG_AW     = $clog2(NUM_REGIONS + 3 + INFO_TOTAL);

  // configuration state
  logic             rg_en    [NUM_REGIONS];
  logic [PAGE_W-1:0] rg_start [NUM_REGIONS];
  logic [PAGE_W:0]  rg_count [NUM_REGIONS];
  fg_perm_t         rg_perm  [NUM_REGIONS];
  fg_perm_t         dflt_perm;
  logic [BANKS-1:0] bank_en;
  logic [31:0]      exec_key;
  fg_perm_t         info_perm [INFO_TOTAL];

  fg_cfg_regs #(
    .NUM_REGIONS (NUM_REGIONS),
    .PAGE_W      (PAGE_W),
    .BANKS       (BANKS),
    .INFO_TOTAL  (INFO_TOTAL),
    .CFG_AW      (CFG_AW)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rg_en     (rg_en),
    .rg_start  (rg_start),
    .rg_count  (rg_count),
    .rg_perm   (rg_perm),
    .dflt_perm (dflt_perm),
    .bank_en   (bank_en),
    .exec_key  (exec_key),
    .info_perm (info_perm)
  );

  // address decode
  logic [PAGE_W-1:0] page;
  logic [BANK_W-1:0] bank;
  logic [PIB_W-1:0]  pib;
  logic              unused_offset;

  assign page          = req_addr[ADDR_W-1 -: PAGE_W];
  assign bank          = page[PAGE_W-1 -: BANK_W];
  assign pib           = page[PIB_W-1:0];
  assign unused_offset = ^req_addr[PAGE_BYTES_LOG2-1:0];

  // data partition: region lookup
  fg_perm_t data_p;

  fg_region_match #(
    .NUM_REGIONS (NUM_REGIONS),
    .PAGE_W      (PAGE_W)
  ) u_match (
    .page      (page),
    .rg_en     (rg_en),
    .rg_start  (rg_start),
    .rg_count  (rg_count),
    .rg_perm   (rg_perm),
    .dflt_perm (dflt_perm),
    .eff_perm  (data_p)
  );

  // information partition: per-page lookup
  logic             info_in_range;
  logic [IDX_W-1:0] info_idx;
  fg_perm_t         info_p;

  assign info_in_range = int'(pib) < INFO_PAGES;
  assign info_idx      = IDX_W'(int'(bank) * INFO_PAGES + int'(pib));
  assign info_p        = info_in_range ? info_perm[info_idx] : '0;

  logic key_ok, bank_ok, allow;
  assign key_ok  = (exec_key == FG_EXEC_KEY);
  assign bank_ok = bank_en[bank];

  fg_decide u_decide (
    .rma           (rma_mode),
    .op            (req_op),
    .info          (req_info),
    .bank_ok       (bank_ok),
    .key_ok        (key_ok),
    .info_in_range (info_in_range),
    .info_p        (info_p),
    .data_p        (data_p),
    .allow         (allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid <= 1'b0;
      chk_allow <= 1'b0;
      chk_err   <= 1'b0;
    end else begin
      chk_valid <= req_valid;
      chk_allow <= req_valid & allow;
      chk_err   <= req_valid & ~allow;
    end
  end

endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int ADDR_W = 20,
  parameter int BANKS  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              rma_mode,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BANKS-1:0]  bank_en,
  input logic [31:0]       exec_key,
  input logic              chk_valid,
  input logic              chk_allow,
  input logic              chk_err
);

  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  logic bank_ok;
  assign bank_ok = bank_en[req_addr[ADDR_W-1 -: BANK_W]];

  // R9
  resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> chk_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!chk_valid && !chk_allow && !chk_err));

  // R9
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> (chk_allow != chk_err));

  // R7
  fetch_key_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd4 && exec_key != 32'hA26A38F7) |=> !chk_allow);

  // R8
  rma_open_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rma_mode && req_op < 3'd4) |=> chk_allow);

  // R8
  rma_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rma_mode && req_op == 3'd4) |=> chk_err);

  // R6
  berase_off_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rma_mode && req_op == 3'd3 && !bank_ok) |=> chk_err);

  // R6
  berase_on_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd3 && bank_ok) |=> chk_allow);

endmodule

bind flash_guard fg_checker #(
  .ADDR_W (ADDR_W),
  .BANKS  (BANKS)
) u_fg_checker (
  .clk       (clk),
  .rst       (rst),
  .rma_mode  (rma_mode),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .bank_en   (bank_en),
  .exec_key  (exec_key),
  .chk_valid (chk_valid),
  .chk_allow (chk_allow),
  .chk_err   (chk_err)
);

// File: tb/test_flash_guard.sv
`timescale 1ns/1ps
module test_flash_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rma_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_info = 1'b0;
  logic [2:0]  req_op = '0;
  logic [19:0] req_addr = '0;
  logic        chk_valid, chk_allow, chk_err;

  always #2 clk = ~clk;

  flash_guard i_flash_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rma_mode(rma_mode), .req_valid(req_valid),
    .req_info(req_info), .req_op(req_op), .req_addr(req_addr),
    .chk_valid(chk_valid), .chk_allow(chk_allow), .chk_err(chk_err)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // behavioural model state
  bit        m_en   [4];
  int        m_start[4];
  int        m_cnt  [4];
  bit [2:0]  m_perm [4];   // {er,pg,rd}
  bit [2:0]  m_dflt;
  bit [1:0]  m_bank;
  bit [31:0] m_key;
  bit [2:0]  m_info [8];

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_en[i] = 0; m_start[i] = 0; m_cnt[i] = 0; m_perm[i] = 0;
    end
    for (int i = 0; i < 8; i++) m_info[i] = 0;
    m_dflt = 0; m_bank = 0; m_key = 0;
  endtask

  task automatic model_write(int a, bit [31:0] d);
    if (a < 4) begin
      m_en[a] = d[0]; m_perm[a] = d[3:1];
      m_start[a] = int'(d[12:4]); m_cnt[a] = int'(d[22:13]);
    end else if (a == 4) m_dflt = d[3:1];
    else if (a == 5) m_bank = d[1:0];
    else if (a == 6) m_key = d;
    else if (a < 15) m_info[a-7] = d[3:1];
  endtask

  function automatic bit model_allow(bit info, int op, int addr, bit rma);
    int page = addr / 2048;
    int bank = page / 256;
    int pib  = page % 256;
    bit [2:0] p;
    bit found = 0;
    if (op > 4) return 0;
    if (rma) return (op != 4);
    if (op == 3) return m_bank[bank];
    if (info) begin
      if (op == 4 || pib >= 4) return 0;
      p = m_info[bank*4 + pib];
    end else begin
      p = m_dflt;
      for (int i = 0; i < 4 && !found; i++) begin
        if (m_en[i] && page >= m_start[i] && page < m_start[i] + m_cnt[i]) begin
          p = m_perm[i]; found = 1;
        end
      end
      if (op == 4) return (m_key == 32'hA26A38F7) && p[0];
    end
    return p[op];
  endfunction

  // one clock: drive at negedge, compare at next negedge
  task automatic step(bit we, int a, bit [31:0] d, bit v, bit info, int op,
                      int addr, string tag);
    bit ev, ea;
    cfg_we = we; cfg_addr = 4'(a); cfg_wdata = d;
    req_valid = v; req_info = info; req_op = 3'(op); req_addr = 20'(addr);
    ev = v;
    ea = v ? model_allow(info, op, addr, rma_mode) : 1'b0;
    @(posedge clk);
    if (we) model_write(a, d);
    @(negedge clk);
    vectors++;
    if (chk_valid !== ev || chk_allow !== ea || chk_err !== (ev & ~ea)) begin
      fails++;
      $display("FAIL %s: op=%0d info=%0d addr=%h got v/a/e=%b%b%b expected %b%b%b",
               tag, op, info, addr, chk_valid, chk_allow, chk_err, ev, ea, ev & ~ea);
    end
  endtask

  task automatic wr(int a, bit [31:0] d, string tag);
    step(1, a, d, 0, 0, 0, 0, tag);
  endtask

  task automatic rq(bit info, int op, int addr, string tag);
    step(0, 0, 0, 1, info, op, addr, tag);
  endtask

  function automatic bit [31:0] rword(bit en, bit rd, bit pg, bit er, int start, int cnt);
    return {9'b0, 10'(cnt), 9'(start), er, pg, rd, en};
  endfunction

  function automatic bit [31:0] pword(bit rd, bit pg, bit er);
    return {28'b0, er, pg, rd, 1'b0};
  endfunction

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    step(0, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
    rq(0, 0, 32'h00000, "R1 read denied after reset");
    rq(0, 4, 32'h00000, "R1 fetch denied after reset");
    rq(1, 0, 32'h00000, "R1 info read denied after reset");
    rq(0, 3, 32'h80000, "R1 bank erase denied after reset");

    // R4: fallback permissions
    wr(4, pword(1, 0, 0), "R10 write fallback");
    rq(0, 0, 5 * 2048, "R4 fallback read");
    rq(0, 1, 5 * 2048, "R4 fallback program denied");

    // R2, R3: regions
    wr(1, rword(1, 1, 1, 0, 10, 5), "R10 write region1");
    wr(0, rword(1, 1, 0, 0, 12, 2), "R10 write region0");
    rq(0, 1, 12 * 2048, "R3 lower index wins");
    rq(0, 1, 13 * 2048 + 100, "R3 lower index wins last page");
    rq(0, 1, 14 * 2048, "R2 region1 after region0 end");
    rq(0, 1, 10 * 2048, "R2 region1 first page");
    rq(0, 1, 15 * 2048, "R2 one past region end");
    rq(0, 1, 9 * 2048, "R2 one before region start");
    wr(0, rword(0, 1, 0, 0, 12, 2), "R10 disable region0");
    rq(0, 1, 12 * 2048, "R2 disabled region ignored");
    wr(2, rword(1, 0, 1, 1, 30, 0), "R10 zero count region");
    rq(0, 2, 30 * 2048, "R2 zero count never matches");

    // R11: bank 1 addressing
    wr(3, rword(1, 0, 0, 1, 256 + 4, 1), "R10 region in bank1");
    rq(0, 2, 32'h82000, "R11 bank1 page4 at 0x82000");
    rq(0, 2, 32'h02000, "R11 bank0 page4 not covered");

    // R5: info pages
    wr(7 + 4 + 2, pword(0, 0, 1), "R10 info bank1 page2");
    rq(1, 2, 32'h81000, "R5 info bank1 page2 erase");
    rq(1, 2, 32'h01000, "R5 info bank0 page2 denied");
    rq(1, 0, 12 * 2048, "R5 info ignores data regions");
    wr(7 + 1, pword(1, 1, 1), "R10 info bank0 page1");
    rq(1, 1, 32'h00800, "R5 info bank0 page1 program");
    rq(1, 0, 5 * 2048, "R5 info page beyond count denied");

    // R6: bank erase
    wr(5, 32'h2, "R10 bank1 erase enable");
    rq(0, 3, 32'h80000, "R6 bank1 erase allowed");
    rq(1, 3, 32'hFF800, "R6 bank1 erase from info");
    rq(0, 3, 32'h00000, "R6 bank0 erase denied");

    // R7: fetch key
    wr(6, 32'hA26A38F6, "R10 near key");
    rq(0, 4, 10 * 2048, "R7 fetch with near key denied");
    wr(6, 32'hA26A38F7, "R10 exact key");
    rq(0, 4, 10 * 2048, "R7 fetch readable page");
    rq(0, 4, 30 * 2048, "R7 fetch via fallback read");
    rq(0, 4, 32'h82000, "R7 fetch no read perm denied");
    rq(1, 4, 32'h00800, "R7 fetch info denied");

    // R9: undefined ops
    rq(0, 5, 10 * 2048, "R9 op5 denied");
    rq(0, 7, 10 * 2048, "R9 op7 denied");

    // R10: same-cycle write uses old config
    step(1, 1, rword(0, 0, 0, 0, 0, 0), 1, 0, 1, 11 * 2048, "R10 same cycle old config");
    rq(0, 1, 11 * 2048, "R10 new config after write");
    wr(15, 32'hFFFFFFFF, "R10 unmapped write");
    rq(0, 1, 40 * 2048, "R10 unmapped write ignored");

    // R8: rma override
    rma_mode = 1'b1;
    rq(0, 1, 32'h00000, "R8 rma program");
    rq(1, 2, 5 * 2048, "R8 rma info erase");
    rq(0, 3, 32'h00000, "R8 rma bank erase");
    rq(0, 4, 10 * 2048, "R8 rma fetch denied");
    rma_mode = 1'b0;

    // R2 R3 R4 R5 R6 R7 random mix
    for (int n = 0; n < 3000; n++) begin
      bit we = ($urandom % 4) == 0;
      int a  = $urandom % 16;
      bit [31:0] d = $urandom;
      int op = $urandom % 6;
      int addr;
      if (a < 4) d = rword($urandom % 4 != 0, d[1], d[2], d[3], 20 + $urandom % 20, $urandom % 12);
      if (a == 6 && d[0]) d = 32'hA26A38F7;
      if ($urandom % 2) addr = (20 + $urandom % 30) * 2048 + $urandom % 2048;
      else addr = $urandom % (1 << 20);
      if (($urandom % 64) == 0) rma_mode = ~rma_mode;
      step(we, a, d, ($urandom % 5) != 0, $urandom % 3 == 0, op, addr, "R3 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule